// File: doc/BRIEF.md
# Hashed Memory Channel Interleave Selector

This block turns a system physical address into the fabric ID of the memory target that owns it. It does this under a programmable interleave rule. The rule gives a start bit, the number of select bits for channel, die and socket, a selection mode, and enables for four high-address XOR windows. The mode picks one of five ways to form the select bits:

- plain contiguous extraction;
- a split XOR hash;
- an XOR hash that can interleave across sockets;
- fine and coarse forms of an extended XOR hash.

The resulting socket, die and channel indices are packed into a fabric ID using per-field masks and shifts. The packed value is then added to the rule's base fabric ID. A rule whose bit counts do not fit its mode raises a configuration error. In that case all indices are forced to zero, so the output is the base ID.

The path is combinational. It can be followed by one output register stage, which is chosen by a parameter and is present by default. Rule, mask and shift inputs are meant to be held static while addresses stream through.

Top module: `ilv_target_sel`

## Requirements
- R1: In plain mode (mode 0) select bit k is addr[start_bit+k]. The channel index takes the lowest chan_bits of these, the die index the next die_bits, and the socket index the next sock_bits.
- R2: In plain mode the window enables have no effect on any output.
- R3: win_en bit 0 enables the 64 KiB window (base bit 16), bit 1 the 2 MiB window (bit 21), bit 2 the 1 GiB window (bit 30) and bit 3 the 1 TiB window (bit 40). Hash row r XORs in bit base+r of each enabled window. The 1 TiB window is used only in modes 3 and 4.
- R4: In split hash mode (mode 1), channel bit 0 is addr[start_bit] XOR row 0, and channel bit j≥1 is addr[11+j] XOR row j.
- R5: In socket hash mode (mode 2) with sock_bits=1, the socket index is addr[start_bit] XOR row 0. Channel bit i is then addr[12+i] XOR row i+1.
- R6: In socket hash mode with sock_bits=0, channel bits are formed as in R4, and addr[14] is also XORed into channel bit 0.
- R7: In fine extended mode (mode 3), hashed bits 0..4 use address bits 8, 9, 12, 13, 14 with rows 0..4. When sock_bits=1 the first hashed bit is the socket index and the channel index comes from the rest.
- R8: In coarse extended mode (mode 4), hashed bits 0..3 use address bits 8, 12, 13, 14 with rows 0, 2, 3, 4. Row 1 and address bit 9 are never used. Socket placement is as in R7.
- R9: Each index is ANDed with its mask, then shifted left by its shift, and the three fields are ORed together. target_fid is base_fid plus that value, modulo 2^16.
- R10: config_error is set in any of these cases. When it is set, all indices are zero and target_fid equals base_fid.
  - start_bit is outside 8..12.
  - A count exceeds its port range.
  - mode is above 4.
  - Mode 1 has sock_bits or die_bits nonzero, or chan_bits>3.
  - Mode 2 has die_bits nonzero, sock_bits>1 or chan_bits>4.
  - Modes 3 and 4 have die_bits nonzero, sock_bits>1 or start_bit≠8.
  - chan_bits+sock_bits exceeds 5 in mode 3 or 4 in mode 4.
- R11: With the output register present, outputs follow the inputs one clock later. An asynchronous low rst_n clears every output to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 64 | System physical address |
| mode | input | 3 | 0 plain, 1 split hash, 2 socket hash, 3 fine extended, 4 coarse extended |
| start_bit | input | 4 | First select address bit (8..12) |
| chan_bits | input | 3 | Channel select bit count |
| die_bits | input | 2 | Die select bit count |
| sock_bits | input | 2 | Socket select bit count |
| win_en | input | 4 | XOR window enables (64K, 2M, 1G, 1T from bit 0) |
| base_fid | input | 16 | Rule base fabric ID |
| chan_mask | input | 16 | Channel field mask |
| die_mask | input | 16 | Die field mask |
| sock_mask | input | 16 | Socket field mask |
| chan_shift | input | 4 | Channel field shift |
| die_shift | input | 4 | Die field shift |
| sock_shift | input | 4 | Socket field shift |
| target_fid | output | 16 | Selected target fabric ID |
| chan_idx | output | 5 | Channel index |
| die_idx | output | 2 | Die index |
| sock_idx | output | 2 | Socket index |
| config_error | output | 1 | Rule inconsistent with mode |

## Verification
Plain-mode addresses put sparse ones in the select bits while the XOR window bits are set and enabled. This separates the field ordering from any accidental hashing.

Each hashed mode gets an address with ones placed so that the result differs depending on several things:
- whether a disabled window leaks in;
- whether the 1 TiB window is wrongly used outside the extended modes;
- whether bit 14 is folded in;
- whether the coarse variant skips row 1.

Rules at the exact bit-count limit of each mode are paired with rules one past it, which exposes off-by-one limits. Directed cases cover mask truncation before shifting, modular wraparound of the base addition, the one-cycle output latency and asynchronous clearing.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [2:0] {
    ILV_PLAIN  = 3'd0,
    ILV_SPLIT  = 3'd1,
    ILV_SOCK   = 3'd2,
    ILV_FINE   = 3'd3,
    ILV_COARSE = 3'd4
  } ilv_mode_e;

  localparam int NUM_WIN    = 4;  // XOR windows
  localparam int HROWS      = 5;  // hash rows / hashed bits
  localparam int SPLIT_MAX  = 3;
  localparam int SOCK_MAX   = 4;
  localparam int FINE_MAX   = 5;
  localparam int COARSE_MAX = 4;
  localparam int START_MIN  = 8;
  localparam int START_MAX  = 12;

  // lowest address bit of each XOR window
  function automatic int win_lsb(input int k);
    case (k)
      0:       return 16;
      1:       return 21;
      2:       return 30;
      default: return 40;
    endcase
  endfunction

  // address bit feeding hashed bit j, fine extended form
  function automatic int fine_bit(input int j);
    case (j)
      0:       return 8;
      1:       return 9;
      2:       return 12;
      3:       return 13;
      default: return 14;
    endcase
  endfunction

  // address bit feeding hashed bit j, coarse extended form
  function automatic int coarse_bit(input int j);
    case (j)
      0:       return 8;
      1:       return 12;
      2:       return 13;
      default: return 14;
    endcase
  endfunction

  // XOR row feeding hashed bit j, coarse extended form (row 1 skipped)
  function automatic int coarse_row(input int j);
    return (j == 0) ? 0 : j + 1;
  endfunction

endpackage

// File: rtl/ilv_xor_rows.sv
module ilv_xor_rows
  import ilv_pkg::*;
(
  input  logic [NUM_WIN*HROWS-1:0] win_bits,  // window k occupies [k*HROWS +: HROWS]
  input  logic [NUM_WIN-1:0]       win_en,
  output logic [HROWS-1:0]         xrow
);

  genvar r, k;
  generate
    for (r = 0; r < HROWS; r++) begin : g_row
      logic [NUM_WIN-1:0] taps;
      for (k = 0; k < NUM_WIN; k++) begin : g_win
        assign taps[k] = win_en[k] & win_bits[k*HROWS + r];
      end
      assign xrow[r] = ^taps;
    end
  endgenerate

endmodule

// File: rtl/ilv_pick.sv
module ilv_pick
  import ilv_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int CH_MAX  = 5,
  parameter int DIE_MAX = 2,
  parameter int SK_MAX  = 2,
  parameter int CB_W    = 3,
  parameter int DB_W    = 2,
  parameter int SB_W    = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  ilv_mode_e          mode,
  input  logic [3:0]         start_bit,
  input  logic [CB_W-1:0]    chan_bits,
  input  logic [DB_W-1:0]    die_bits,
  input  logic [SB_W-1:0]    sock_bits,
  input  logic [HROWS-1:0]   xrow,
  output logic [CH_MAX-1:0]  chan,
  output logic [DIE_MAX-1:0] die,
  output logic [SK_MAX-1:0]  sock
);

  localparam int EXT_W = CH_MAX + DIE_MAX + SK_MAX;

  logic [ADDR_W-1:0]  shifted;
  logic [EXT_W-1:0]   pv, pv_die, pv_sock;
  logic [HROWS-1:0]   hv, hsel;
  logic [CH_MAX-1:0]  cm;
  logic [DIE_MAX-1:0] dm;
  logic [SK_MAX-1:0]  sm;
  logic               sock_first;

  always_comb begin
    shifted    = addr >> start_bit;
    pv         = shifted[EXT_W-1:0];
    pv_die     = pv >> chan_bits;
    pv_sock    = pv >> (int'(chan_bits) + int'(die_bits));
    cm         = ~({CH_MAX{1'b1}}  << chan_bits);
    dm         = ~({DIE_MAX{1'b1}} << die_bits);
    sm         = ~({SK_MAX{1'b1}}  << sock_bits);
    sock_first = (sock_bits != '0);

    // hashed select bits per mode
    hv = '0;
    case (mode)
      ILV_SPLIT, ILV_SOCK: begin
        hv[0] = addr[start_bit] ^ xrow[0];
        for (int j = 1; j < HROWS; j++) hv[j] = addr[11 + j] ^ xrow[j];
        if (mode == ILV_SOCK && !sock_first) hv[0] = hv[0] ^ addr[14];
      end
      ILV_FINE: begin
        for (int j = 0; j < HROWS; j++) hv[j] = addr[fine_bit(j)] ^ xrow[j];
      end
      ILV_COARSE: begin
        for (int j = 0; j < HROWS - 1; j++)
          hv[j] = addr[coarse_bit(j)] ^ xrow[coarse_row(j)];
      end
      default: hv = '0;
    endcase

    hsel = sock_first ? (hv >> 1) : hv;

    if (mode == ILV_PLAIN) begin
      chan = pv[CH_MAX-1:0] & cm;
      die  = pv_die[DIE_MAX-1:0] & dm;
      sock = pv_sock[SK_MAX-1:0] & sm;
    end else begin
      chan = CH_MAX'(hsel) & cm;
      die  = '0;
      sock = sock_first ? SK_MAX'(hv[0]) : '0;
    end
  end

endmodule

// File: rtl/ilv_cfg_chk.sv
module ilv_cfg_chk
  import ilv_pkg::*;
#(
  parameter int CH_MAX  = 5,
  parameter int DIE_MAX = 2,
  parameter int SK_MAX  = 2,
  parameter int CB_W    = 3,
  parameter int DB_W    = 2,
  parameter int SB_W    = 2
) (
  input  logic [2:0]      mode,
  input  logic [3:0]      start_bit,
  input  logic [CB_W-1:0] chan_bits,
  input  logic [DB_W-1:0] die_bits,
  input  logic [SB_W-1:0] sock_bits,
  output logic            err
);

  int cb, db, sb, sb_total;

  always_comb begin
    cb       = int'(chan_bits);
    db       = int'(die_bits);
    sb       = int'(sock_bits);
    sb_total = cb + sb;
    err      = 1'b0;
    if (int'(start_bit) < START_MIN || int'(start_bit) > START_MAX) err = 1'b1;
    if (cb > CH_MAX || db > DIE_MAX || sb > SK_MAX) err = 1'b1;
    case (ilv_mode_e'(mode))
      ILV_PLAIN:  ;
      ILV_SPLIT:  if (sb != 0 || db != 0 || cb > SPLIT_MAX) err = 1'b1;
      ILV_SOCK:   if (db != 0 || sb > 1 || cb > SOCK_MAX) err = 1'b1;
      ILV_FINE:   if (db != 0 || sb > 1 || sb_total > FINE_MAX ||
                      int'(start_bit) != START_MIN) err = 1'b1;
      ILV_COARSE: if (db != 0 || sb > 1 || sb_total > COARSE_MAX ||
                      int'(start_bit) != START_MIN) err = 1'b1;
      default:    err = 1'b1;
    endcase
  end

endmodule

// File: rtl/ilv_pack.sv
module ilv_pack #(
  parameter int FID_W   = 16,
  parameter int CH_MAX  = 5,
  parameter int DIE_MAX = 2,
  parameter int SK_MAX  = 2,
  parameter int SH_W    = 4
) (
  input  logic [CH_MAX-1:0]  chan,
  input  logic [DIE_MAX-1:0] die,
  input  logic [SK_MAX-1:0]  sock,
  input  logic [FID_W-1:0]   base_fid,
  input  logic [FID_W-1:0]   chan_mask,
  input  logic [FID_W-1:0]   die_mask,
  input  logic [FID_W-1:0]   sock_mask,
  input  logic [SH_W-1:0]    chan_shift,
  input  logic [SH_W-1:0]    die_shift,
  input  logic [SH_W-1:0]    sock_shift,
  output logic [FID_W-1:0]   fid
);

  logic [FID_W-1:0] cf, df, sf;

  always_comb begin
    // mask first, then shift into place
    cf  = (FID_W'(chan) & chan_mask) << chan_shift;
    df  = (FID_W'(die)  & die_mask)  << die_shift;
    sf  = (FID_W'(sock) & sock_mask) << sock_shift;
    fid = base_fid + (cf | df | sf);
  end

endmodule

// File: rtl/ilv_target_sel.sv
module ilv_target_sel
  import ilv_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FID_W   = 16,
  parameter int CH_MAX  = 5,
  parameter int DIE_MAX = 2,
  parameter int SK_MAX  = 2,
  parameter bit OUT_REG = 1'b1,
  localparam int CB_W   = $clog2(CH_MAX + 1),
  localparam int DB_W   = $clog2(DIE_MAX + 1),
  localparam int SB_W   = $clog2(SK_MAX + 1),
  localparam int SH_W   = $clog2(FID_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2:0]         mode,
  input  logic [3:0]         start_bit,
  input  logic [CB_W-1:0]    chan_bits,
  input  logic [DB_W-1:0]    die_bits,
  input  logic [SB_W-1:0]    sock_bits,
  input  logic [NUM_WIN-1:0] win_en,
  input  logic [FID_W-1:0]   base_fid,
  input  logic [FID_W-1:0]   chan_mask,
  input  logic [FID_W-1:0]   die_mask,
  input  logic [FID_W-1:0]   sock_mask,
  input  logic [SH_W-1:0]    chan_shift,
  input  logic [SH_W-1:0]    die_shift,
  input  logic [SH_W-1:0]    sock_shift,
  output logic [FID_W-1:0]   target_fid,
  output logic [CH_MAX-1:0]  chan_idx,
  output logic [DIE_MAX-1:0] die_idx,
  output logic [SK_MAX-1:0]  sock_idx,
  output logic               config_error
);

  ilv_mode_e                mode_e;
  logic [NUM_WIN*HROWS-1:0] win_bits;
  logic [NUM_WIN-1:0]       win_eff;
  logic [HROWS-1:0]         xrow;
  logic [CH_MAX-1:0]        chan_c, d_chan;
  logic [DIE_MAX-1:0]       die_c, d_die;
  logic [SK_MAX-1:0]        sock_c, d_sock;
  logic                     d_err;
  logic [FID_W-1:0]         d_fid;
  logic                     rst_q;

  assign mode_e = ilv_mode_e'(mode);

  // gather the window slices; 1 TiB window only for the extended modes
  genvar k;
  generate
    for (k = 0; k < NUM_WIN; k++) begin : g_slice
      assign win_bits[k*HROWS +: HROWS] = addr[win_lsb(k) +: HROWS];
    end
  endgenerate

  always_comb begin
    win_eff    = win_en;
    win_eff[3] = win_en[3] & (mode_e == ILV_FINE || mode_e == ILV_COARSE);
  end

  ilv_xor_rows u_rows (
    .win_bits (win_bits),
    .win_en   (win_eff),
    .xrow     (xrow)
  );

  ilv_pick #(
    .ADDR_W (ADDR_W), .CH_MAX (CH_MAX), .DIE_MAX (DIE_MAX), .SK_MAX (SK_MAX),
    .CB_W (CB_W), .DB_W (DB_W), .SB_W (SB_W)
  ) u_pick (
    .addr      (addr),
    .mode      (mode_e),
    .start_bit (start_bit),
    .chan_bits (chan_bits),
    .die_bits  (die_bits),
    .sock_bits (sock_bits),
    .xrow      (xrow),
    .chan      (chan_c),
    .die       (die_c),
    .sock      (sock_c)
  );

  ilv_cfg_chk #(
    .CH_MAX (CH_MAX), .DIE_MAX (DIE_MAX), .SK_MAX (SK_MAX),
    .CB_W (CB_W), .DB_W (DB_W), .SB_W (SB_W)
  ) u_chk (
    .mode      (mode),
    .start_bit (start_bit),
    .chan_bits (chan_bits),
    .die_bits  (die_bits),
    .sock_bits (sock_bits),
    .err       (d_err)
  );

  // next-state: indices cleared on a bad rule
  always_comb begin
    d_chan = d_err ? '0 : chan_c;
    d_die  = d_err ? '0 : die_c;
    d_sock = d_err ? '0 : sock_c;
  end

  ilv_pack #(
    .FID_W (FID_W), .CH_MAX (CH_MAX), .DIE_MAX (DIE_MAX), .SK_MAX (SK_MAX),
    .SH_W (SH_W)
  ) u_pack (
    .chan       (d_chan),
    .die        (d_die),
    .sock       (d_sock),
    .base_fid   (base_fid),
    .chan_mask  (chan_mask),
    .die_mask   (die_mask),
    .sock_mask  (sock_mask),
    .chan_shift (chan_shift),
    .die_shift  (die_shift),
    .sock_shift (sock_shift),
    .fid        (d_fid)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [1:0]         rsync;
      logic [FID_W-1:0]   q_fid;
      logic [CH_MAX-1:0]  q_chan;
      logic [DIE_MAX-1:0] q_die;
      logic [SK_MAX-1:0]  q_sock;
      logic               q_err;

      // asynchronous assert, synchronous release
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= '0;
        else        rsync <= {rsync[0], 1'b1};
      end
      assign rst_q = rsync[1];

      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) begin
          q_fid  <= '0;
          q_chan <= '0;
          q_die  <= '0;
          q_sock <= '0;
          q_err  <= 1'b0;
        end else begin
          q_fid  <= d_fid;
          q_chan <= d_chan;
          q_die  <= d_die;
          q_sock <= d_sock;
          q_err  <= d_err;
        end
      end

      assign target_fid   = q_fid;
      assign chan_idx     = q_chan;
      assign die_idx      = q_die;
      assign sock_idx     = q_sock;
      assign config_error = q_err;

      // R11
      reg_lat_chk: assert property (@(posedge clk) disable iff (!rst_q)
        1'b1 |=> (target_fid == $past(d_fid) && config_error == $past(d_err)));
    end else begin : g_comb
      assign rst_q        = rst_n;
      assign target_fid   = d_fid;
      assign chan_idx     = d_chan;
      assign die_idx      = d_die;
      assign sock_idx     = d_sock;
      assign config_error = d_err;
    end
  endgenerate

  // R10
  err_base_chk: assert property (@(posedge clk) disable iff (!rst_q)
    d_err |-> (d_fid == base_fid));

  // R1
  chan_fit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !d_err |-> ((chan_c >> chan_bits) == '0));

  // R4
  split_nosk_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_e == ILV_SPLIT && !d_err) |-> (sock_c == '0 && die_c == '0));

  // R7
  ext_nodie_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_e != ILV_PLAIN) |-> (die_c == '0));

endmodule

// File: tb/sim_ilv_target_sel.sv
module sim_ilv_target_sel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] addr;
  logic [2:0]  mode;
  logic [3:0]  start_bit;
  logic [2:0]  chan_bits;
  logic [1:0]  die_bits, sock_bits;
  logic [3:0]  win_en;
  logic [15:0] base_fid, chan_mask, die_mask, sock_mask;
  logic [3:0]  chan_shift, die_shift, sock_shift;
  logic [15:0] target_fid;
  logic [4:0]  chan_idx;
  logic [1:0]  die_idx, sock_idx;
  logic        config_error;

  always #4 clk = ~clk;  // 125 MHz

  ilv_target_sel u0 (
    .clk (clk), .rst_n (rst_n), .addr (addr), .mode (mode),
    .start_bit (start_bit), .chan_bits (chan_bits), .die_bits (die_bits),
    .sock_bits (sock_bits), .win_en (win_en), .base_fid (base_fid),
    .chan_mask (chan_mask), .die_mask (die_mask), .sock_mask (sock_mask),
    .chan_shift (chan_shift), .die_shift (die_shift), .sock_shift (sock_shift),
    .target_fid (target_fid), .chan_idx (chan_idx), .die_idx (die_idx),
    .sock_idx (sock_idx), .config_error (config_error)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0]  md;
    logic [3:0]  st;
    logic [2:0]  cb;
    logic [1:0]  db;
    logic [1:0]  sb;
    logic [3:0]  win;
    logic [63:0] a;
    logic [4:0]  ech;
    logic [1:0]  edie;
    logic [1:0]  esk;
    logic        eerr;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [63:0] ONES = '1;

  localparam vec_t VT [21] = '{
    // R1 R2: plain, windows set and enabled but ignored
    '{3'd0, 4'd9,  3'd3, 2'd0, 2'd1, 4'hF, 64'h0000_0000_4021_1A00, 5'd5,  2'd0, 2'd1, 1'b0, 8'd1},
    '{3'd0, 4'd8,  3'd2, 2'd2, 2'd1, 4'hF, 64'h0000_0000_0000_1600, 5'd2,  2'd1, 2'd1, 1'b0, 8'd1},
    '{3'd0, 4'd12, 3'd5, 2'd0, 2'd0, 4'h0, 64'h0000_0000_0001_5000, 5'd21, 2'd0, 2'd0, 1'b0, 8'd1},
    // R4 R3: split hash, 1T bit set but unused
    '{3'd1, 4'd9,  3'd3, 2'd0, 2'd0, 4'hF, 64'h0000_0100_8003_2200, 5'd4,  2'd0, 2'd0, 1'b0, 8'd4},
    // R3: only 64K window enabled, 2M bit set
    '{3'd1, 4'd10, 3'd2, 2'd0, 2'd0, 4'h1, 64'h0000_0000_0022_1400, 5'd1,  2'd0, 2'd0, 1'b0, 8'd3},
    // R5: socket first
    '{3'd2, 4'd9,  3'd3, 2'd0, 2'd1, 4'h7, 64'h0000_0002_0006_2200, 5'd5,  2'd0, 2'd1, 1'b0, 8'd5},
    // R6: bit 14 folded
    '{3'd2, 4'd8,  3'd2, 2'd0, 2'd0, 4'h7, 64'h0000_0000_0000_5000, 5'd3,  2'd0, 2'd0, 1'b0, 8'd6},
    // R7: fine, 5 bits, 1T row used
    '{3'd3, 4'd8,  3'd5, 2'd0, 2'd0, 4'hF, 64'h0000_0202_0004_1100, 5'd11, 2'd0, 2'd0, 1'b0, 8'd7},
    '{3'd3, 4'd8,  3'd2, 2'd0, 2'd1, 4'h1, 64'h0000_0000_0027_0200, 5'd2,  2'd0, 2'd1, 1'b0, 8'd7},
    // R8: coarse skips bit 9 and row 1
    '{3'd4, 4'd8,  3'd3, 2'd0, 2'd0, 4'hF, 64'h0000_0100_0182_1200, 5'd5,  2'd0, 2'd0, 1'b0, 8'd8},
    '{3'd4, 4'd8,  3'd4, 2'd0, 2'd0, 4'h0, 64'h0000_0000_0000_4100, 5'd9,  2'd0, 2'd0, 1'b0, 8'd8},
    // R10: inconsistent rules
    '{3'd1, 4'd9,  3'd2, 2'd0, 2'd1, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    '{3'd1, 4'd9,  3'd4, 2'd0, 2'd0, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    '{3'd2, 4'd9,  3'd2, 2'd1, 2'd0, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    '{3'd3, 4'd9,  3'd3, 2'd0, 2'd0, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    '{3'd4, 4'd8,  3'd4, 2'd0, 2'd1, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    '{3'd0, 4'd13, 3'd2, 2'd0, 2'd0, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    '{3'd5, 4'd8,  3'd1, 2'd0, 2'd0, 4'h0, ONES, 5'd0, 2'd0, 2'd0, 1'b1, 8'd10},
    // boundaries at the limit (R7, R5, R1)
    '{3'd3, 4'd8,  3'd4, 2'd0, 2'd1, 4'h0, ONES, 5'd15, 2'd0, 2'd1, 1'b0, 8'd7},
    '{3'd2, 4'd8,  3'd4, 2'd0, 2'd1, 4'h0, ONES, 5'd15, 2'd0, 2'd1, 1'b0, 8'd5},
    '{3'd0, 4'd12, 3'd5, 2'd2, 2'd2, 4'h0, ONES, 5'd31, 2'd3, 2'd3, 1'b0, 8'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_fid(input logic [4:0] ch, input logic [1:0] di,
                                          input logic [1:0] sk);
    logic [15:0] f;
    f = ((16'(ch) & chan_mask) << chan_shift) | ((16'(di) & die_mask) << die_shift) |
        ((16'(sk) & sock_mask) << sock_shift);
    return base_fid + f;
  endfunction

  task automatic set_pack_default();
    base_fid  = 16'h0100;
    chan_mask = 16'hFFFF; die_mask = 16'hFFFF; sock_mask = 16'hFFFF;
    chan_shift = 4'd0; die_shift = 4'd6; sock_shift = 4'd10;
  endtask

  task automatic apply(input vec_t v);
    mode = v.md; start_bit = v.st; chan_bits = v.cb; die_bits = v.db;
    sock_bits = v.sb; win_en = v.win; addr = v.a;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_n = 1'b1;
    addr = '0; mode = '0; start_bit = 4'd8; chan_bits = '0; die_bits = '0;
    sock_bits = '0; win_en = '0;
    set_pack_default();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset target_fid", 32'(target_fid), 32'h0);
    chk("R11 reset chan_idx", 32'(chan_idx), 32'h0);
    chk("R11 reset config_error", 32'(config_error), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 21; i++) begin
      apply(VT[i]);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d chan_idx", VT[i].rq, i), 32'(chan_idx), 32'(VT[i].ech));
      chk($sformatf("R%0d vec%0d die_idx", VT[i].rq, i), 32'(die_idx), 32'(VT[i].edie));
      chk($sformatf("R%0d vec%0d sock_idx", VT[i].rq, i), 32'(sock_idx), 32'(VT[i].esk));
      chk($sformatf("R%0d vec%0d config_error", VT[i].rq, i), 32'(config_error), 32'(VT[i].eerr));
      chk($sformatf("R%0d vec%0d target_fid", VT[i].rq, i), 32'(target_fid),
          32'(exp_fid(VT[i].ech, VT[i].edie, VT[i].esk)));
    end

    // R9: mask before shift, wraparound of base add
    mode = 3'd0; start_bit = 4'd8; chan_bits = 3'd3; die_bits = 2'd0; sock_bits = 2'd0;
    win_en = 4'h0; addr = 64'h700;
    chan_mask = 16'h0005; chan_shift = 4'd4; base_fid = 16'hFFF0;
    @(negedge clk);
    chk("R9 mask-then-shift wrap target_fid", 32'(target_fid), 32'h0040);
    // R9: die field, mask drops low bit
    chan_bits = 3'd1; die_bits = 2'd2; addr = 64'h600;
    die_mask = 16'h0002; die_shift = 4'd14; base_fid = 16'h0001;
    @(negedge clk);
    chk("R9 die field target_fid", 32'(target_fid), 32'h8001);
    set_pack_default();

    // R11: one-cycle latency
    chan_bits = 3'd3; die_bits = 2'd0; addr = 64'h700;
    @(negedge clk);
    chk("R11 latency first", 32'(chan_idx), 32'd7);
    addr = 64'h300;
    #1;
    chk("R11 latency holds before edge", 32'(chan_idx), 32'd7);
    @(negedge clk);
    chk("R11 latency after edge", 32'(chan_idx), 32'd3);

    // R11: asynchronous clear
    rst_n = 1'b0;
    #1;
    chk("R11 async clear chan_idx", 32'(chan_idx), 32'd0);
    chk("R11 async clear target_fid", 32'(target_fid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule